// File: doc/BRIEF.md
# Soft Mute Attenuation Ramp

This block applies one gain to both channels of a stereo digital audio stream. It keeps a programmed attenuation index in the range 0 to 106. Each index is 0.5 dB below the one before it, so the indices lie on a logarithmic curve. A dedicated index, 107, stands for full cut, which is zero gain. The block runs from the 256x sample-rate core clock, and a one-cycle strobe marks each sample period.

Pulling the active-low mute input low does not silence the output at once. The applied index moves step by step from the programmed value to full cut over 1024 sample periods. Releasing mute moves it back to the programmed value over the same span. If mute changes partway through a ramp, the ramp turns around from where it stands. A standby input forces the outputs to zero and freezes the ramp. The programmed index and the ramp position survive standby.

Top module: `softmute_ramp`

## Requirements
- R1: After reset (`rst_n` low) both outputs are 0, the programmed index is 0 (0 dB, unity gain) and the ramp counter is 0. The first strobe therefore passes the inputs through unchanged.
- R2: The index i selects the gain g(i) = M[i mod 12] >> (i div 12), with M = 32768, 30929, 29193, 27554, 26008, 24548, 23170, 21870, 20643, 19484, 18390, 17358 for k = 0..11. Index 107 gives g = 0. Each output is floor(x * g / 32768), taken as a signed value.
- R3: `set_we` high for one clock loads `set_idx` into the programmed index. A value above 106 is stored as 106.
- R4: While `mute_n` is low and `stby_n` is high, each strobe increments the ramp counter by one, up to a limit of 1024. The applied index is set + floor((107 - set) * counter / 1024), so the output reaches zero gain after 1024 strobes and stays there.
- R5: While `mute_n` is high and `stby_n` is high, each strobe decrements the ramp counter, down to 0. The applied index therefore returns to the programmed index, including a value that was loaded during mute.
- R6: A change of `mute_n` in the middle of a ramp reverses the counter from its present value. There is no jump.
- R7: The outputs register only on a strobe cycle and hold between strobes. Each output uses the applied index as it stood before that strobe's own step and before any load in the same cycle.
- R8: While `stby_n` is low, a strobe registers 0 on both outputs. The ramp counter holds its value. The programmed index is kept, and a load in standby still takes effect.
- R9: The left and right channels apply the same gain, each to its own input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, 256x the sample rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | One-cycle pulse per sample period |
| mute_n | input | 1 | Mute request, active low |
| stby_n | input | 1 | Standby, active low |
| set_we | input | 1 | Load strobe for the programmed index |
| set_idx | input | 7 | Attenuation index to load (0..106) |
| x_l | input | 16 | Left sample in, signed |
| x_r | input | 16 | Right sample in, signed |
| y_l | output | 16 | Left sample out, signed |
| y_r | output | 16 | Right sample out, signed |

## Verification
Two functions can fall on the same clock edge: a ramp step on a strobe, and a load of a new programmed index. That output must be scaled with the old index and the old counter, and the new index takes effect from the next strobe on. The bench makes loads and mute edges land on strobe cycles, both in directed sequences and in random traffic, and compares every output with a bench model that applies the ordering defined in R7. A mute reversal on a strobe cycle is judged the same way: the counter turns around by exactly one step.

// File: rtl/smr_pkg.sv
package smr_pkg;

    localparam int unsigned GAIN_W    = 16;
    localparam int unsigned GAIN_FRAC = 15;
    localparam int unsigned OCT_STEPS = 12;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_DOWN = 2'd1,
        RAMP_UP   = 2'd2
    } ramp_dir_e;

    // One octave of 0.5 dB mantissas in Q1.15
    function automatic logic [GAIN_W-1:0] mant_of(input int unsigned k);
        case (k)
            0:       mant_of = 16'd32768;
            1:       mant_of = 16'd30929;
            2:       mant_of = 16'd29193;
            3:       mant_of = 16'd27554;
            4:       mant_of = 16'd26008;
            5:       mant_of = 16'd24548;
            6:       mant_of = 16'd23170;
            7:       mant_of = 16'd21870;
            8:       mant_of = 16'd20643;
            9:       mant_of = 16'd19484;
            10:      mant_of = 16'd18390;
            11:      mant_of = 16'd17358;
            default: mant_of = '0;
        endcase
    endfunction

endpackage

// File: rtl/smr_gain_lut.sv
module smr_gain_lut
    import smr_pkg::*;
#(
    parameter int unsigned NSTEP = 107,
    parameter int unsigned IW    = 7
) (
    input  logic [IW-1:0]     idx,
    output logic [GAIN_W-1:0] gain
);

    int unsigned oct;
    int unsigned rem;

    always_comb begin
        oct = 32'(idx) / OCT_STEPS;
        rem = 32'(idx) % OCT_STEPS;
        if (32'(idx) >= NSTEP) begin
            gain = '0;
        end else begin
            gain = mant_of(rem) >> oct;
        end
    end

endmodule

// File: rtl/smr_ramp_ctl.sv
module smr_ramp_ctl
    import smr_pkg::*;
#(
    parameter int unsigned NSTEP    = 107,
    parameter int unsigned RAMP_LEN = 1024,
    parameter int unsigned IW       = 7,
    parameter int unsigned CW       = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_stb,
    input  logic          mute_n,
    input  logic          stby_n,
    input  logic          set_we,
    input  logic [IW-1:0] set_idx,
    output logic [IW-1:0] set_out,
    output logic [CW-1:0] ctr_out,
    output logic [IW-1:0] pos
);

    localparam int unsigned RSH = $clog2(RAMP_LEN);
    localparam int unsigned PW  = IW + CW;
    localparam logic [IW-1:0] MAX_SET = IW'(NSTEP - 1);
    localparam logic [CW-1:0] CTR_TOP = CW'(RAMP_LEN);

    typedef struct packed {
        logic [IW-1:0] set;
        logic [CW-1:0] ctr;
    } ramp_st_t;

    ramp_st_t  st_d, st_q;
    ramp_dir_e dir;
    logic [IW-1:0] span;
    logic [PW-1:0] prod;

    // Direction of the next step
    always_comb begin
        dir = RAMP_HOLD;
        if (smp_stb && stby_n) begin
            if (!mute_n && st_q.ctr != CTR_TOP) begin
                dir = RAMP_UP;
            end else if (mute_n && st_q.ctr != '0) begin
                dir = RAMP_DOWN;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (set_we) begin
            st_d.set = (set_idx > MAX_SET) ? MAX_SET : set_idx;
        end
        case (dir)
            RAMP_UP:   st_d.ctr = st_q.ctr + 1'b1;
            RAMP_DOWN: st_d.ctr = st_q.ctr - 1'b1;
            default:   st_d.ctr = st_q.ctr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Applied index: linear share of the distance to cut
    always_comb begin
        span = IW'(NSTEP) - st_q.set;
        prod = PW'(span) * PW'(st_q.ctr);
        pos  = st_q.set + IW'(prod >> RSH);
    end

    assign set_out = st_q.set;
    assign ctr_out = st_q.ctr;

endmodule

// File: rtl/smr_chan_mult.sv
module smr_chan_mult
    import smr_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_stb,
    input  logic                 stby_n,
    input  logic signed [DW-1:0] x,
    input  logic [GAIN_W-1:0]    gain,
    output logic signed [DW-1:0] y
);

    localparam int unsigned PW = DW + GAIN_W + 1;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    logic signed [DW-1:0] y_d, y_q;

    always_comb begin
        prod   = x * $signed({1'b0, gain});
        scaled = prod >>> GAIN_FRAC;
        y_d    = y_q;
        if (smp_stb) begin
            y_d = stby_n ? scaled[DW-1:0] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q <= '0;
        end else begin
            y_q <= y_d;
        end
    end

    assign y = y_q;

endmodule

// File: rtl/softmute_ramp.sv
module softmute_ramp
    import smr_pkg::*;
#(
    parameter int unsigned DW       = 16,
    parameter int unsigned NSTEP    = 107,
    parameter int unsigned RAMP_LEN = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_stb,
    input  logic                 mute_n,
    input  logic                 stby_n,
    input  logic                 set_we,
    input  logic [6:0]           set_idx,
    input  logic signed [DW-1:0] x_l,
    input  logic signed [DW-1:0] x_r,
    output logic signed [DW-1:0] y_l,
    output logic signed [DW-1:0] y_r
);

    localparam int unsigned IW    = $clog2(NSTEP + 1);
    localparam int unsigned CW    = $clog2(RAMP_LEN + 1);
    localparam int unsigned NCHAN = 2;

    logic [IW-1:0]     ramp_set;
    logic [CW-1:0]     ramp_ctr;
    logic [IW-1:0]     ramp_pos;
    logic [GAIN_W-1:0] ramp_gain;

    logic signed [DW-1:0] x_arr [NCHAN];
    logic signed [DW-1:0] y_arr [NCHAN];

    smr_ramp_ctl #(
        .NSTEP    (NSTEP),
        .RAMP_LEN (RAMP_LEN),
        .IW       (IW),
        .CW       (CW)
    ) i_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_stb (smp_stb),
        .mute_n  (mute_n),
        .stby_n  (stby_n),
        .set_we  (set_we),
        .set_idx (IW'(set_idx)),
        .set_out (ramp_set),
        .ctr_out (ramp_ctr),
        .pos     (ramp_pos)
    );

    smr_gain_lut #(
        .NSTEP (NSTEP),
        .IW    (IW)
    ) i_lut (
        .idx  (ramp_pos),
        .gain (ramp_gain)
    );

    assign x_arr[0] = x_l;
    assign x_arr[1] = x_r;

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        smr_chan_mult #(
            .DW (DW)
        ) i_mult (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_stb (smp_stb),
            .stby_n  (stby_n),
            .x       (x_arr[c]),
            .gain    (ramp_gain),
            .y       (y_arr[c])
        );
    end

    assign y_l = y_arr[0];
    assign y_r = y_arr[1];

endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
    parameter int unsigned DW       = 16,
    parameter int unsigned NSTEP    = 107,
    parameter int unsigned RAMP_LEN = 1024,
    parameter int unsigned IW       = 7,
    parameter int unsigned CW       = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_stb,
    input logic          mute_n,
    input logic          stby_n,
    input logic [IW-1:0] set_q,
    input logic [CW-1:0] ctr_q,
    input logic [IW-1:0] pos,
    input logic [15:0]   gain,
    input logic [DW-1:0] y_l,
    input logic [DW-1:0] y_r
);

    assert_ctr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q <= CW'(RAMP_LEN));

    assert_ctr_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && stby_n && !mute_n && ctr_q != CW'(RAMP_LEN))
        |=> ctr_q == $past(ctr_q) + 1'b1);

    assert_ctr_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && stby_n && mute_n && ctr_q != '0)
        |=> ctr_q == $past(ctr_q) - 1'b1);

    assert_rest_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q == '0) |-> (pos == set_q));

    assert_pos_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= set_q) && (32'(pos) <= NSTEP));

    assert_cut_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(pos) == NSTEP) |-> (gain == '0));

    assert_hold_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(y_l) && $stable(y_r)));

    assert_stby_ctr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_n |=> $stable(ctr_q));

    assert_stby_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !stby_n) |=> (y_l == '0 && y_r == '0));

endmodule

bind softmute_ramp smr_checker #(
    .DW       (DW),
    .NSTEP    (NSTEP),
    .RAMP_LEN (RAMP_LEN),
    .IW       (IW),
    .CW       (CW)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_stb (smp_stb),
    .mute_n  (mute_n),
    .stby_n  (stby_n),
    .set_q   (ramp_set),
    .ctr_q   (ramp_ctr),
    .pos     (ramp_pos),
    .gain    (ramp_gain),
    .y_l     (y_l),
    .y_r     (y_r)
);

// File: tb/test_softmute_ramp.sv
module test_softmute_ramp;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 1'b0;
    logic mute_n = 1'b1;
    logic stby_n = 1'b1;
    logic set_we = 1'b0;
    logic [6:0] set_idx = '0;
    logic signed [15:0] x_l = '0;
    logic signed [15:0] x_r = '0;
    logic signed [15:0] y_l, y_r;

    always #2 clk = ~clk;

    softmute_ramp i_softmute_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_stb (smp_stb),
        .mute_n  (mute_n),
        .stby_n  (stby_n),
        .set_we  (set_we),
        .set_idx (set_idx),
        .x_l     (x_l),
        .x_r     (x_r),
        .y_l     (y_l),
        .y_r     (y_r)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model state
    int m_set = 0;
    int m_ctr = 0;
    int e_l   = 0;
    int e_r   = 0;

    function automatic int mant(input int k);
        case (k)
            0: return 32768;   1: return 30929;   2: return 29193;
            3: return 27554;   4: return 26008;   5: return 24548;
            6: return 23170;   7: return 21870;   8: return 20643;
            9: return 19484;  10: return 18390;  11: return 17358;
            default: return 0;
        endcase
    endfunction

    function automatic int gain_of(input int i);
        if (i >= 107) return 0;
        return mant(i % 12) >> (i / 12);
    endfunction

    function automatic int pos_of(input int s, input int c);
        return s + (((107 - s) * c) >> 10);
    endfunction

    function automatic int scale(input int x, input int g);
        longint p;
        p = longint'(x) * longint'(g);
        return int'(p >>> 15);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit stb, input bit mn, input bit sb, input bit we,
                        input int idx, input int xl, input int xr, input string tag);
        int g;
        @(negedge clk);
        smp_stb = stb;
        mute_n  = mn;
        stby_n  = sb;
        set_we  = we;
        set_idx = 7'(idx);
        x_l     = 16'(xl);
        x_r     = 16'(xr);
        if (stb) begin
            g   = gain_of(pos_of(m_set, m_ctr));
            e_l = sb ? scale(xl, g) : 0;
            e_r = sb ? scale(xr, g) : 0;
            if (sb) begin
                if (!mn && m_ctr < 1024) m_ctr++;
                else if (mn && m_ctr > 0) m_ctr--;
            end
        end
        if (we) m_set = (idx > 106) ? 106 : idx;
        @(posedge clk);
        #1;
        check(stb ? tag : "R7", int'(y_l), e_l);
        check(stb ? tag : "R7", int'(y_r), e_r);
    endtask

    // Strobe every other clock
    task automatic run(input int n, input bit mn, input bit sb,
                       input int xl, input int xr, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1'b1, mn, sb, 1'b0, 0, xl, xr, tag);
            step(1'b0, mn, sb, 1'b0, 0, xl, xr, "R7");
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7301));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", int'(y_l), 0);
        check("R1", int'(y_r), 0);

        // R1: unity at reset index
        step(1'b1, 1'b1, 1'b1, 1'b0, 0, 1000, -1000, "R1");
        check("R1", int'(y_l), 1000);

        // R2: every index, full-scale in both signs
        for (int i = 0; i < 107; i++) begin
            step(1'b0, 1'b1, 1'b1, 1'b1, i, 0, 0, "R3");
            step(1'b1, 1'b1, 1'b1, 1'b0, 0, 32767, -32768, "R2");
        end
        check("R2", int'(y_l), 70);

        // R3: load above range saturates at 106
        step(1'b0, 1'b1, 1'b1, 1'b1, 120, 0, 0, "R3");
        step(1'b1, 1'b1, 1'b1, 1'b0, 0, 32767, 32767, "R3");
        check("R3", int'(y_r), scale(32767, gain_of(106)));

        // R7: load on a strobe edge uses old index for that output
        step(1'b1, 1'b1, 1'b1, 1'b1, 20, 32767, 12345, "R7");
        check("R7", int'(y_l), scale(32767, gain_of(106)));
        step(1'b1, 1'b1, 1'b1, 1'b0, 0, 32767, 12345, "R7");
        check("R7", int'(y_l), scale(32767, gain_of(20)));

        // R4: full mute ramp reaches cut and stays there
        run(1024, 1'b0, 1'b1, 30000, -22222, "R4");
        run(3, 1'b0, 1'b1, 30000, -22222, "R4");
        check("R4", int'(y_l), 0);

        // R5: release returns to a level loaded while muted
        step(1'b0, 1'b0, 1'b1, 1'b1, 4, 0, 0, "R5");
        run(1025, 1'b1, 1'b1, 30000, -22222, "R5");
        check("R5", int'(y_l), scale(30000, gain_of(4)));

        // R6: reversal mid-ramp
        run(300, 1'b0, 1'b1, 25000, 25000, "R6");
        run(150, 1'b1, 1'b1, 25000, 25000, "R6");
        run(40, 1'b0, 1'b1, 25000, 25000, "R6");
        run(200, 1'b1, 1'b1, 25000, 25000, "R6");
        check("R6", int'(y_l), scale(25000, gain_of(4)));

        // R8: standby zeroes outputs, keeps counter and index
        run(100, 1'b0, 1'b1, 20000, 20000, "R8");
        run(50, 1'b0, 1'b0, 20000, 20000, "R8");
        check("R8", int'(y_l), 0);
        step(1'b0, 1'b0, 1'b0, 1'b1, 10, 0, 0, "R8");
        run(5, 1'b0, 1'b1, 20000, 20000, "R8");
        check("R8", int'(y_l), scale(20000, gain_of(pos_of(10, 104))));

        // R9 and mixed: random traffic, independent channel inputs
        begin
            bit mn = 1'b1;
            bit sb = 1'b1;
            for (int i = 0; i < 20000; i++) begin
                if ($urandom_range(0, 299) == 0) mn = ~mn;
                if ($urandom_range(0, 999) == 0) sb = ~sb;
                step(($urandom_range(0, 2) == 0), mn, sb,
                     ($urandom_range(0, 149) == 0), int'($urandom_range(0, 127)),
                     int'($urandom_range(0, 65535)) - 32768,
                     int'($urandom_range(0, 65535)) - 32768, "R9");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule